// File: doc/BRIEF.md
# Clarke and Park transform engine

This block is a coprocessor for field-oriented motor control. It turns three-phase quantities into a rotating two-axis frame, and it can also go the other way. A host loads operand registers over a simple write port. All operands and results are 12-bit two's complement. Writing one of the two angle addresses starts a transformation.

The reverse path takes the three phase inputs and applies a Clarke transform to get an orthogonal (alpha, beta) pair. It then rotates that pair by minus the angle to get direct and quadrature components.

The forward path rotates the direct/quadrature inputs by plus the angle to get an (x, y) pair. It then expands that pair into three phase values with an inverse Clarke transform.

Each path takes two calculation cycles and shares one rotator and one sine/cosine lookup. The intermediate pair becomes visible one cycle before the final results. The busy and done flags tell the host when the results are ready.

Top module: `vecxform_engine`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `busy` and `done` are 0 and every result output is 0.
- R2: When the engine is idle and `wr_en` is high, the operand registers load `wr_data` at these `wr_addr` values:
  - 0: phase 1
  - 1: phase 2
  - 2: phase 3
  - 3: direct input
  - 4: quadrature input

  A write to address 7 changes nothing.
- R3: When the engine is idle, a write to address 5 takes `wr_data` as the angle, starts the reverse path and raises `busy` after that edge. The timing then runs as follows:
  - `alpha_o`/`beta_o` update on the next edge.
  - `d_o`/`q_o` update on the edge after that.
  - On that same later edge, `busy` falls and `done` rises.
- R4: When the engine is idle, a write to address 6 starts the forward path with the same timing as R3. `x_o`/`y_o` update on the first calculation edge and `pa_o`/`pb_o`/`pc_o` update on the second.
- R5: Every write accepted while `busy` is high is ignored. This covers operand writes and angle writes.
- R6: `done` stays 1 until the next accepted start. It is 0 from the edge that raises `busy`.
- R7: The Clarke step gives `alpha = ph1` and `beta = sat(floor((ph2 - ph3) * 2365 / 4096))`.
- R8: The angle is an unsigned 12-bit fraction of a full turn (512 means 45 degrees). Only its upper 6 bits k are used:
  - `s = round(2048 * sin(2*pi*k/64))` and `c` is the same function at (k+16) mod 64.
  - The reverse rotation gives `d = sat(floor((alpha*c + beta*s) / 2048))` and `q = sat(floor((beta*c - alpha*s) / 2048))`.
- R9: The forward rotation gives `x = sat(floor((vd*c - vq*s) / 2048))` and `y = sat(floor((vd*s + vq*c) / 2048))`.
- R10: The inverse Clarke step gives:
  - `pa = x`
  - `pb = sat(floor((3547*y - 2048*x) / 4096))`
  - `pc = sat(floor((-3547*y - 2048*x) / 4096))`
- R11: `sat` clamps every result to the range -2048 to 2047.
- R12: Results that a path does not write keep their values. All results hold while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select (see R2, R3, R4) |
| wr_data | input | 12 | Write data |
| busy | output | 1 | Transformation in progress |
| done | output | 1 | Last transformation finished |
| alpha_o | output | 12 | Clarke alpha result (reverse path) |
| beta_o | output | 12 | Clarke beta result (reverse path) |
| d_o | output | 12 | Direct component (reverse path) |
| q_o | output | 12 | Quadrature component (reverse path) |
| x_o | output | 12 | Rotated x (forward path) |
| y_o | output | 12 | Rotated y (forward path) |
| pa_o | output | 12 | Phase A result (forward path) |
| pb_o | output | 12 | Phase B result (forward path) |
| pc_o | output | 12 | Phase C result (forward path) |

## Verification
If the sequencer state is wrong, `busy` or `done` shows it within one to two edges of a start. A path could also write the other path's results, and that is visible on the next edge.

A wrong quadrant fold or a wrong table entry only shows at angles that reach that entry. A missing clamp only shows on inputs near full scale. For that reason the stimulus sweeps all 64 angle steps and drives operands to their extremes. Every output is compared against a behavioural model on every clock, so any error is caught in the cycle where it first reaches a port.

// File: rtl/vx_pkg.sv
package vx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ONE, ST_TWO} vx_state_e;

  localparam logic [2:0] A_PH1 = 3'd0;
  localparam logic [2:0] A_PH2 = 3'd1;
  localparam logic [2:0] A_PH3 = 3'd2;
  localparam logic [2:0] A_VD  = 3'd3;
  localparam logic [2:0] A_VQ  = 3'd4;
  localparam logic [2:0] A_REV = 3'd5;
  localparam logic [2:0] A_FWD = 3'd6;

  // 4096/sqrt(3) and 4096*sqrt(3)/2, rounded
  localparam int K_INV_SQ3  = 2365;
  localparam int K_HALF_SQ3 = 3547;
  localparam int TRIG_FRAC  = 11;
endpackage

// File: rtl/vx_trig.sv
// Sine/cosine from a quarter-wave table with quadrant folding.
module vx_trig #(
  parameter int LUT_W = 4,
  parameter int TW    = 13,
  localparam int STEP_W = LUT_W + 2
) (
  input  logic [STEP_W-1:0]    step,
  output logic signed [TW-1:0] sin_o,
  output logic signed [TW-1:0] cos_o
);
  localparam logic [LUT_W:0]    QTR   = (LUT_W+1)'(1 << LUT_W);
  localparam logic [STEP_W-1:0] QSTEP = STEP_W'(1 << LUT_W);

  // round(2048*sin(i*pi/32)), i = 0..16
  function automatic logic signed [TW-1:0] quarter(input logic [LUT_W:0] i);
    case (i)
      5'd0:  return TW'(0);
      5'd1:  return TW'(201);
      5'd2:  return TW'(400);
      5'd3:  return TW'(595);
      5'd4:  return TW'(784);
      5'd5:  return TW'(965);
      5'd6:  return TW'(1138);
      5'd7:  return TW'(1299);
      5'd8:  return TW'(1448);
      5'd9:  return TW'(1583);
      5'd10: return TW'(1703);
      5'd11: return TW'(1806);
      5'd12: return TW'(1892);
      5'd13: return TW'(1960);
      5'd14: return TW'(2009);
      5'd15: return TW'(2038);
      5'd16: return TW'(2048);
      default: return TW'(0);
    endcase
  endfunction

  function automatic logic signed [TW-1:0] fold(input logic [STEP_W-1:0] k);
    logic [LUT_W:0] idx;
    logic signed [TW-1:0] mag;
    idx = k[LUT_W] ? (QTR - {1'b0, k[LUT_W-1:0]}) : {1'b0, k[LUT_W-1:0]};
    mag = quarter(idx);
    return k[LUT_W+1] ? -mag : mag;
  endfunction

  always_comb begin
    sin_o = fold(step);
    cos_o = fold(step + QSTEP);
  end
endmodule

// File: rtl/vx_rot.sv
// Planar rotation: o0 = i0*c - i1*s', o1 = i0*s' + i1*c, s' = inv ? -s : s
module vx_rot
  import vx_pkg::*;
#(
  parameter int DW = 12,
  parameter int TW = 13
) (
  input  logic signed [DW-1:0] i0,
  input  logic signed [DW-1:0] i1,
  input  logic signed [TW-1:0] s,
  input  logic signed [TW-1:0] c,
  input  logic                 inv,
  output logic signed [DW-1:0] o0,
  output logic signed [DW-1:0] o1
);
  localparam int PW = DW + TW + 2;
  localparam logic signed [PW-1:0] HI = PW'((2 ** (DW-1)) - 1);
  localparam logic signed [PW-1:0] LO = -PW'(2 ** (DW-1));

  function automatic logic signed [DW-1:0] sat(input logic signed [PW-1:0] v);
    if (v > HI) return HI[DW-1:0];
    if (v < LO) return LO[DW-1:0];
    return v[DW-1:0];
  endfunction

  logic signed [TW-1:0] sx;
  logic signed [PW-1:0] acc0, acc1;

  always_comb begin
    sx   = inv ? -s : s;
    acc0 = PW'(i0) * PW'(c) - PW'(i1) * PW'(sx);
    acc1 = PW'(i0) * PW'(sx) + PW'(i1) * PW'(c);
    o0   = sat(acc0 >>> TRIG_FRAC);
    o1   = sat(acc1 >>> TRIG_FRAC);
  end
endmodule

// File: rtl/vx_clarke.sv
// Clarke beta term and inverse Clarke phase B/C terms.
module vx_clarke
  import vx_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic signed [DW-1:0] p2,
  input  logic signed [DW-1:0] p3,
  input  logic signed [DW-1:0] x,
  input  logic signed [DW-1:0] y,
  output logic signed [DW-1:0] beta,
  output logic signed [DW-1:0] pb,
  output logic signed [DW-1:0] pc
);
  localparam int PW = DW + 16;
  localparam logic signed [PW-1:0] HI = PW'((2 ** (DW-1)) - 1);
  localparam logic signed [PW-1:0] LO = -PW'(2 ** (DW-1));
  localparam logic signed [PW-1:0] KB = PW'(K_INV_SQ3);
  localparam logic signed [PW-1:0] KH = PW'(K_HALF_SQ3);
  localparam logic signed [PW-1:0] KX = PW'(2048);

  function automatic logic signed [DW-1:0] sat(input logic signed [PW-1:0] v);
    if (v > HI) return HI[DW-1:0];
    if (v < LO) return LO[DW-1:0];
    return v[DW-1:0];
  endfunction

  logic signed [PW-1:0] diff, acc_b, acc_pb, acc_pc;

  always_comb begin
    diff   = PW'(p2) - PW'(p3);
    acc_b  = diff * KB;
    acc_pb = PW'(y) * KH - PW'(x) * KX;
    acc_pc = -(PW'(y) * KH) - PW'(x) * KX;
    beta   = sat(acc_b >>> 12);
    pb     = sat(acc_pb >>> 12);
    pc     = sat(acc_pc >>> 12);
  end
endmodule

// File: rtl/vecxform_engine.sv
module vecxform_engine
  import vx_pkg::*;
#(
  parameter int DW    = 12,
  parameter int LUT_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [2:0]           wr_addr,
  input  logic [DW-1:0]        wr_data,
  output logic                 busy,
  output logic                 done,
  output logic signed [DW-1:0] alpha_o,
  output logic signed [DW-1:0] beta_o,
  output logic signed [DW-1:0] d_o,
  output logic signed [DW-1:0] q_o,
  output logic signed [DW-1:0] x_o,
  output logic signed [DW-1:0] y_o,
  output logic signed [DW-1:0] pa_o,
  output logic signed [DW-1:0] pb_o,
  output logic signed [DW-1:0] pc_o
);
  localparam int TW     = DW + 1;
  localparam int STEP_W = LUT_W + 2;

  vx_state_e st_q;
  logic signed [DW-1:0] ph1_q, ph2_q, ph3_q, vd_q, vq_q;
  logic [STEP_W-1:0]    ang_q;
  logic                 fwd_q;

  logic signed [TW-1:0] sin_v, cos_v;
  logic signed [DW-1:0] rot_i0, rot_i1, rot_o0, rot_o1;
  logic signed [DW-1:0] cl_beta, cl_pb, cl_pc;
  logic                 start;

  assign start  = wr_en && (st_q == ST_IDLE) && (wr_addr == A_REV || wr_addr == A_FWD);
  assign rot_i0 = (st_q == ST_ONE) ? vd_q : alpha_o;
  assign rot_i1 = (st_q == ST_ONE) ? vq_q : beta_o;

  vx_trig #(.LUT_W(LUT_W), .TW(TW)) u_trig (
    .step(ang_q), .sin_o(sin_v), .cos_o(cos_v)
  );

  vx_rot #(.DW(DW), .TW(TW)) u_rot (
    .i0(rot_i0), .i1(rot_i1), .s(sin_v), .c(cos_v), .inv(!fwd_q),
    .o0(rot_o0), .o1(rot_o1)
  );

  vx_clarke #(.DW(DW)) u_clarke (
    .p2(ph2_q), .p3(ph3_q), .x(x_o), .y(y_o),
    .beta(cl_beta), .pb(cl_pb), .pc(cl_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      busy  <= 1'b0;
      done  <= 1'b0;
      fwd_q <= 1'b0;
      ang_q <= '0;
      ph1_q <= '0; ph2_q <= '0; ph3_q <= '0; vd_q <= '0; vq_q <= '0;
      alpha_o <= '0; beta_o <= '0; d_o <= '0; q_o <= '0;
      x_o <= '0; y_o <= '0; pa_o <= '0; pb_o <= '0; pc_o <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (wr_en) begin
            case (wr_addr)
              A_PH1: ph1_q <= $signed(wr_data);
              A_PH2: ph2_q <= $signed(wr_data);
              A_PH3: ph3_q <= $signed(wr_data);
              A_VD:  vd_q  <= $signed(wr_data);
              A_VQ:  vq_q  <= $signed(wr_data);
              A_REV, A_FWD: begin
                ang_q <= wr_data[DW-1 -: STEP_W];
                fwd_q <= (wr_addr == A_FWD);
                st_q  <= ST_ONE;
                busy  <= 1'b1;
                done  <= 1'b0;
              end
              default: ;
            endcase
          end
        end
        ST_ONE: begin
          if (fwd_q) begin
            x_o <= rot_o0;
            y_o <= rot_o1;
          end else begin
            alpha_o <= ph1_q;
            beta_o  <= cl_beta;
          end
          st_q <= ST_TWO;
        end
        ST_TWO: begin
          if (fwd_q) begin
            pa_o <= x_o;
            pb_o <= cl_pb;
            pc_o <= cl_pc;
          end else begin
            d_o <= rot_o0;
            q_o <= rot_o1;
          end
          st_q <= ST_IDLE;
          busy <= 1'b0;
          done <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (busy && !done));

  // R3
  stage_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy ##1 (!busy && done));

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(d_o) && $stable(q_o) && $stable(pa_o) &&
                           $stable(pb_o) && $stable(pc_o) && $stable(alpha_o) &&
                           $stable(x_o)));

  // R5
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en) |=> ($stable(ph1_q) && $stable(vd_q) && $stable(ang_q)));

  // R7
  beta_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ONE && !fwd_q && ph2_q > ph3_q) |=> (beta_o >= 0));

  // R10
  pa_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_TWO && fwd_q) |=> (pa_o == $past(x_o)));
endmodule

// File: tb/vecxform_engine_bench.sv
`timescale 1ns/1ps
module vecxform_engine_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = 3'd0;
  logic [11:0] wr_data = 12'd0;
  logic        busy, done;
  logic signed [11:0] alpha_o, beta_o, d_o, q_o, x_o, y_o, pa_o, pb_o, pc_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  vecxform_engine u_vecxform_engine (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .alpha_o(alpha_o), .beta_o(beta_o), .d_o(d_o),
    .q_o(q_o), .x_o(x_o), .y_o(y_o), .pa_o(pa_o), .pb_o(pb_o), .pc_o(pc_o)
  );

  // ---------------- behavioural reference model ----------------
  int m_ph1, m_ph2, m_ph3, m_vd, m_vq, m_ang, m_fwd, m_st, m_busy, m_done;
  int m_al, m_be, m_d, m_q, m_x, m_y, m_pa, m_pb, m_pc;

  function automatic int sat(int v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  function automatic int trig(int k);
    real r;
    r = 2048.0 * $sin(2.0 * 3.14159265358979 * real'(k % 64) / 64.0);
    return int'(r);
  endfunction

  function automatic int s12(logic [11:0] v);
    return int'($signed(v));
  endfunction

  always @(posedge clk) begin
    int s, c;
    if (rst) begin
      m_ph1 = 0; m_ph2 = 0; m_ph3 = 0; m_vd = 0; m_vq = 0; m_ang = 0; m_fwd = 0;
      m_st = 0; m_busy = 0; m_done = 0;
      m_al = 0; m_be = 0; m_d = 0; m_q = 0; m_x = 0; m_y = 0; m_pa = 0; m_pb = 0; m_pc = 0;
    end else begin
      s = trig(m_ang >> 6);
      c = trig((m_ang >> 6) + 16);
      case (m_st)
        0: if (wr_en) begin
          case (wr_addr)
            3'd0: m_ph1 = s12(wr_data);
            3'd1: m_ph2 = s12(wr_data);
            3'd2: m_ph3 = s12(wr_data);
            3'd3: m_vd  = s12(wr_data);
            3'd4: m_vq  = s12(wr_data);
            3'd5, 3'd6: begin
              m_ang = int'(wr_data); m_fwd = (wr_addr == 3'd6) ? 1 : 0;
              m_st = 1; m_busy = 1; m_done = 0;
            end
            default: ;
          endcase
        end
        1: begin
          if (m_fwd != 0) begin
            m_x = sat((m_vd * c - m_vq * s) >>> 11);
            m_y = sat((m_vd * s + m_vq * c) >>> 11);
          end else begin
            m_al = m_ph1;
            m_be = sat(((m_ph2 - m_ph3) * 2365) >>> 12);
          end
          m_st = 2;
        end
        default: begin
          if (m_fwd != 0) begin
            m_pa = m_x;
            m_pb = sat((3547 * m_y - 2048 * m_x) >>> 12);
            m_pc = sat((-3547 * m_y - 2048 * m_x) >>> 12);
          end else begin
            m_d = sat((m_al * c + m_be * s) >>> 11);
            m_q = sat((m_be * c - m_al * s) >>> 11);
          end
          m_st = 0; m_busy = 0; m_done = 1;
        end
      endcase
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R3 busy", int'(busy), m_busy);
      chk("R6 done", int'(done), m_done);
      chk("R7 alpha_o", int'(alpha_o), m_al);
      chk("R7 beta_o", int'(beta_o), m_be);
      chk("R8 d_o", int'(d_o), m_d);
      chk("R8 q_o", int'(q_o), m_q);
      chk("R9 x_o", int'(x_o), m_x);
      chk("R9 y_o", int'(y_o), m_y);
      chk("R10 pa_o", int'(pa_o), m_pa);
      chk("R10 pb_o", int'(pb_o), m_pb);
      chk("R10 pc_o", int'(pc_o), m_pc);
    end
  end

  // caller stands at a negedge; returns at the next negedge
  task automatic wr(input logic [2:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = 12'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int keep;
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 d_o", int'(d_o), 0);
    chk("R1 pa_o", int'(pa_o), 0);
    chk("R1 beta_o", int'(beta_o), 0);

    // R2 operand load, address 7 ignored
    wr(3'd0, 100); wr(3'd1, 300); wr(3'd2, -200); wr(3'd7, 555);
    wr(3'd5, 0); idle(2);
    chk("R2 alpha after addr7 write", int'(alpha_o), 100);

    // R5 writes during busy are ignored
    keep = int'(x_o);
    wr(3'd5, 512);
    wr(3'd0, -300);
    wr(3'd6, 1024);
    chk("R5 forward start ignored", int'(x_o), keep);
    chk("R6 done after reverse", int'(done), 1);
    idle(5);
    chk("R6 done held", int'(done), 1);
    wr(3'd5, 1024);
    chk("R6 done cleared", int'(done), 0);
    chk("R3 busy after start", int'(busy), 1);
    idle(2);
    chk("R5 ph1 unchanged", int'(alpha_o), 100);

    // R12 / R4 forward leaves reverse results alone
    keep = int'(d_o);
    wr(3'd3, 1000); wr(3'd4, -700);
    wr(3'd6, 512);
    chk("R4 busy after forward start", int'(busy), 1);
    idle(2);
    chk("R12 d_o held over forward", int'(d_o), keep);

    // R11 saturation
    wr(3'd1, 2047); wr(3'd2, -2048); wr(3'd5, 3000); idle(2);
    chk("R11 beta clamp", int'(beta_o), 2047);
    wr(3'd3, 2047); wr(3'd4, 2047); wr(3'd6, 512); idle(2);
    chk("R11 y clamp", int'(y_o), 2047);
    chk("R11 pb value", int'(pb_o), 1772);

    // sweep all angle steps, both paths
    for (int k = 0; k < 64; k++) begin
      wr(3'd0, 1500 - 40 * k); wr(3'd1, -900 + 25 * k); wr(3'd2, 700 - 11 * k);
      wr(3'd5, k * 64 + (k % 7)); idle(2);
      wr(3'd3, -1800 + 50 * k); wr(3'd4, 1200 - 33 * k);
      wr(3'd6, k * 64 + 63); idle(2);
    end

    // random traffic, including writes while busy
    for (int i = 0; i < 600; i++) begin
      wr(3'($urandom_range(0, 7)), int'($urandom_range(0, 4095)));
      idle(int'($urandom_range(0, 2)));
    end
    idle(4);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule